// File: doc/BRIEF.md
# Operator Console Memory Sequencer

This block is the operator console of a small accumulator machine, reduced to its memory commands. An operator sets a word on the switch register and pulses one of three commands. Set-address copies the switches into the program counter. Store writes the switches into memory at the program counter and then advances the counter. Inspect reads the memory word at the program counter into the buffer register and leaves the counter unchanged. Every value moves through one internal transfer path: an X holding register for switch data, a Y holding register for memory data, and a Z selector that feeds the destination registers and the write-data bus.

The three commands are plain one-cycle strobes with no handshake. While a command is in progress, `busy` is high and any new strobe is dropped. There is no back-pressure on the memory side. The port is a synchronous, word-addressed RAM with a fixed one-cycle read latency, so read data for an address presented in one cycle is returned in the next. The program counter, the memory address register and the buffer register are outputs so that surrounding logic and tests can see them.

Top module: `console_seq`

## Requirements
- R1: After reset, `pc`, `ma` and `mb` are 0, and `busy` and `mem_we` are low.
- R2: A set-address strobe accepted while idle loads `pc` with `sw` at the end of the following cycle. `ma`, `mb` and memory stay unchanged, and `mem_we` stays low.
- R3: A store strobe accepted while idle is followed by one bus cycle. In that cycle `mem_we` is 1, `mem_addr` equals `pc` and `mem_wdata` equals the `sw` value captured at acceptance. At the end of that cycle `ma` takes the old `pc`, `mb` takes the written word, and `pc` advances by one.
- R4: An inspect strobe accepted while idle drives `mem_addr` = `pc` with `mem_we` low for one cycle, and `ma` takes `pc`. Two cycles later `mb` holds the memory word at that address. `pc` does not change.
- R5: `busy` rises in the cycle after a strobe is accepted. It stays high for 1 cycle for set-address and store, and for 3 cycles for inspect.
- R6: Strobes that arrive while `busy` is high are ignored: they change no register and cause no write.
- R7: When several strobes are high in the same cycle, set-address has priority over store, and store has priority over inspect.
- R8: The `pc` advance wraps modulo 4096, so a store at address 4095 leaves `pc` = 0.
- R9: `mem_we` is high only in the bus cycle of a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw | input | 12 | Switch-register word |
| setaddr_stb | input | 1 | Set-address command strobe |
| store_stb | input | 1 | Store command strobe |
| inspect_stb | input | 1 | Inspect command strobe |
| busy | output | 1 | A command is in progress |
| pc | output | 12 | Program counter |
| ma | output | 12 | Memory address register |
| mb | output | 12 | Memory buffer register |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, one cycle after the address |

## Verification
The embedded assertions check these properties on every cycle:
- The program counter holds still outside a set-address or store bus cycle.
- A store advances the counter by exactly one, with wrap-around, and loads the buffer with the word it wrote.
- Only an inspect enters the read phase, and the latched command cannot change while busy.
- A write never occurs outside a busy store.

Other behaviour can only be shown by the bench's scenarios, with a behavioural model compared every cycle:
- Inspect returns the right memory word through the Y path, including a word that was just stored.
- Strobe priority, and strobes dropped while busy.
- Counter wrap from the top address.
- The exact busy length of each command.

// File: rtl/console_pkg.sv
package console_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_SETADDR = 2'd1,
    CMD_STORE   = 2'd2,
    CMD_INSPECT = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_READ = 2'd2,
    ST_XFER = 2'd3
  } st_e;

  // strobe index order is also priority order (index 0 highest)
  localparam int NUM_CMDS = 3;
endpackage

// File: rtl/console_arb.sv
module console_arb
  import console_pkg::*;
#(
  parameter int N = NUM_CMDS
) (
  input  logic [N-1:0] req,
  input  logic         busy,
  output logic         go,
  output cmd_e         pick
);
  logic [N-1:0] grant;

  // fixed priority: lowest index wins (R7)
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    pick = CMD_NONE;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) pick = cmd_e'(2'(i + 1));
    end
  end

  // strobes are only taken while idle (R6)
  assign go = !busy && (|req);
endmodule

// File: rtl/console_fsm.sv
module console_fsm
  import console_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  cmd_e pick,
  output st_e  state,
  output cmd_e cmd_q,
  output logic busy
);
  st_e state_n;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: if (go) state_n = ST_BUS;
      ST_BUS:  state_n = (cmd_q == CMD_INSPECT) ? ST_READ : ST_IDLE;
      ST_READ: state_n = ST_XFER;
      ST_XFER: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cmd_q <= CMD_NONE;
    end else begin
      state <= state_n;
      if (state == ST_IDLE && go) cmd_q <= pick;
    end
  end

  assign busy = (state != ST_IDLE);

  assert_inspect_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUS && cmd_q == CMD_INSPECT) |=> (state == ST_READ));

  assert_short_cmd_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUS && cmd_q != CMD_INSPECT) |=> (state == ST_IDLE));

  assert_cmd_held_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(cmd_q));
endmodule

// File: rtl/console_datapath.sv
module console_datapath
  import console_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  st_e               state,
  input  cmd_e              cmd_q,
  input  logic [DATA_W-1:0] sw,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ma,
  output logic [DATA_W-1:0] mb,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

  logic [DATA_W-1:0] x_q, y_q, z;
  logic              bus, z_from_y;

  assign bus      = (state == ST_BUS);
  assign z_from_y = (state == ST_XFER);
  assign z        = z_from_y ? y_q : x_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      if (state == ST_IDLE && go) x_q <= sw;
      if (state == ST_READ) y_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      ma <= '0;
      mb <= '0;
    end else begin
      if (bus) begin
        unique case (cmd_q)
          CMD_SETADDR: pc <= z[ADDR_W-1:0];
          CMD_STORE: begin
            ma <= pc;
            mb <= z;
            pc <= pc + PC_STEP;
          end
          CMD_INSPECT: ma <= pc;
          default: ;
        endcase
      end
      if (z_from_y) mb <= z;
    end
  end

  assign mem_we    = bus && (cmd_q == CMD_STORE);
  assign mem_addr  = bus ? pc : ma;
  assign mem_wdata = z;

  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus || cmd_q == CMD_INSPECT) |=> $stable(pc));

  assert_pc_wrap_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus && cmd_q == CMD_STORE) |=> (pc == ADDR_W'($past(pc) + PC_STEP)));

  assert_store_mb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus && cmd_q == CMD_STORE) |=> (mb == $past(mem_wdata)));
endmodule

// File: rtl/console_seq.sv
module console_seq
  import console_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sw,
  input  logic              setaddr_stb,
  input  logic              store_stb,
  input  logic              inspect_stb,
  output logic              busy,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ma,
  output logic [DATA_W-1:0] mb,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [NUM_CMDS-1:0] req;
  logic                go;
  cmd_e                pick, cmd_q;
  st_e                 state;

  assign req = {inspect_stb, store_stb, setaddr_stb};

  console_arb #(.N(NUM_CMDS)) arb_i (
    .req  (req),
    .busy (busy),
    .go   (go),
    .pick (pick)
  );

  console_fsm fsm_i (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .pick  (pick),
    .state (state),
    .cmd_q (cmd_q),
    .busy  (busy)
  );

  console_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .state     (state),
    .cmd_q     (cmd_q),
    .sw        (sw),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .ma        (ma),
    .mb        (mb),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assert_write_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_write_at_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == pc));
endmodule

// File: tb/console_seq_tb.sv
module console_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int AW = 12;
  localparam int DEPTH = 1 << AW;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] sw = '0;
  logic setaddr_stb = 1'b0, store_stb = 1'b0, inspect_stb = 1'b0;
  logic busy, mem_we;
  logic [AW-1:0] pc, ma, mem_addr;
  logic [DW-1:0] mb, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  logic [DW-1:0] ram [DEPTH];
  logic [DW-1:0] shadow [DEPTH];

  int checks = 0;
  int fails = 0;

  // behavioural reference state
  int m_phase = 0;  // 0 idle, 1 bus, 2 read, 3 xfer
  int m_cmd = 0;    // 1 setaddr, 2 store, 3 inspect
  int m_x = 0, m_y = 0, m_pc = 0, m_ma = 0, m_mb = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  console_seq #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw(sw),
    .setaddr_stb(setaddr_stb), .store_stb(store_stb), .inspect_stb(inspect_stb),
    .busy(busy), .pc(pc), .ma(ma), .mb(mb),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] seed_word(int i);
    return DW'(i * 37 + 5);
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ram[i] = seed_word(i);
      shadow[i] = seed_word(i);
    end
  end

  // synchronous memory, one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cmd = 0; m_x = 0; m_y = 0; m_pc = 0; m_ma = 0; m_mb = 0;
    end else begin
      case (m_phase)
        0: if (setaddr_stb || store_stb || inspect_stb) begin
          m_cmd = setaddr_stb ? 1 : (store_stb ? 2 : 3);
          m_x = int'(sw);
          m_phase = 1;
        end
        1: begin
          if (m_cmd == 1) begin
            m_pc = m_x % DEPTH; m_phase = 0;
          end else if (m_cmd == 2) begin
            shadow[m_pc] = DW'(m_x);
            m_ma = m_pc; m_mb = m_x; m_pc = (m_pc + 1) % DEPTH; m_phase = 0;
          end else begin
            m_ma = m_pc; m_phase = 2;
          end
        end
        2: begin m_y = int'(shadow[m_ma]); m_phase = 3; end
        default: begin m_mb = m_y; m_phase = 0; end
      endcase
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 busy", int'(busy), int'(m_phase != 0));
      chk("R9 mem_we", int'(mem_we), int'(m_phase == 1 && m_cmd == 2));
      chk("R2 pc", int'(pc), m_pc);
      chk("R4 ma", int'(ma), m_ma);
      chk("R4 mb", int'(mb), m_mb);
      if (m_phase == 1) chk("R4 mem_addr", int'(mem_addr), m_pc);
      if (m_phase == 1 && m_cmd == 2) chk("R3 mem_wdata", int'(mem_wdata), m_x);
    end
  end

  task automatic issue(bit a, bit s, bit n, logic [DW-1:0] v, output int blen);
    @(negedge clk);
    sw = v; setaddr_stb = a; store_stb = s; inspect_stb = n;
    @(negedge clk);
    setaddr_stb = 0; store_stb = 0; inspect_stb = 0;
    blen = 0;
    while (busy) begin blen++; @(negedge clk); end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int n;
    logic [AW-1:0] keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pc", int'(pc), 0);
    chk("R1 ma", int'(ma), 0);
    chk("R1 mb", int'(mb), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 mem_we", int'(mem_we), 0);
    rst_n = 1'b1;

    // R2 set address
    issue(1, 0, 0, 12'h123, n);
    chk("R2 pc loaded", int'(pc), 'h123);
    chk("R2 ma kept", int'(ma), 0);
    chk("R5 setaddr busy len", n, 1);

    // R3 store
    issue(0, 1, 0, 12'hABC, n);
    chk("R3 mem written", int'(ram[12'h123]), 'hABC);
    chk("R3 mb", int'(mb), 'hABC);
    chk("R3 ma", int'(ma), 'h123);
    chk("R3 pc advanced", int'(pc), 'h124);
    chk("R5 store busy len", n, 1);

    // R4 inspect of seeded word
    issue(0, 0, 1, 12'h000, n);
    chk("R4 mb read", int'(mb), int'(seed_word('h124)));
    chk("R4 pc unchanged", int'(pc), 'h124);
    chk("R5 inspect busy len", n, 3);

    // R4 inspect of a stored word
    issue(1, 0, 0, 12'h123, n);
    issue(0, 0, 1, 12'h000, n);
    chk("R4 mb stored word", int'(mb), 'hABC);

    // R8 wrap
    issue(1, 0, 0, 12'hFFF, n);
    issue(0, 1, 0, 12'h555, n);
    chk("R8 pc wrapped", int'(pc), 0);
    chk("R8 top word", int'(ram[12'hFFF]), 'h555);

    // R6 strobes during busy ignored
    issue(1, 0, 0, 12'h200, n);
    @(negedge clk);
    sw = 12'h777; inspect_stb = 1;
    @(negedge clk);
    inspect_stb = 0; setaddr_stb = 1; store_stb = 1;
    @(negedge clk);
    setaddr_stb = 0; store_stb = 0;
    while (busy) @(negedge clk);
    chk("R6 pc kept", int'(pc), 'h200);
    chk("R6 no write", int'(ram[12'h200]), int'(seed_word('h200)));
    chk("R6 mb inspect", int'(mb), int'(seed_word('h200)));

    // R7 priority
    issue(1, 1, 1, 12'h300, n);
    chk("R7 setaddr wins", int'(pc), 'h300);
    chk("R7 no write", int'(ram[12'h300]), int'(seed_word('h300)));
    issue(0, 1, 1, 12'h0F0, n);
    chk("R7 store wins", int'(ram[12'h300]), 'h0F0);
    chk("R7 pc advanced", int'(pc), 'h301);

    // mixed traffic, checked by the per-cycle model
    for (int k = 0; k < 24; k++) begin
      keep = AW'(k * 13);
      issue(1, 0, 0, keep, n);
      issue(0, 1, 0, DW'(k * 91 + 7), n);
      issue(1, 0, 0, keep, n);
      issue(0, 0, 1, '0, n);
      chk("R4 readback", int'(mb), (k * 91 + 7) % DEPTH);
    end

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule